// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the control logic of a bulk-erase flash device. The array itself is outside the block. A host talks to it over an asynchronous-style microprocessor bus with active-low chip select, output enable and write enable, an address and an 8-bit data bus. A high-voltage-present input gates every operation that alters the contents. The tri-state data pins are modelled as a data vector plus a drive enable. All bus inputs are sampled on a free-running clock.

Every complete write strobe is a command to the register. Depending on the code written, later reads return array data, a manufacturer or device identifier, or verify data. Verify data is the array word at a latched address, sensed with a margin flag that the array uses. Program and erase each open a pulse toward the array. A stop timer bounds that pulse. When the timer runs out, the controller waits in an inactive state until the host sends the matching verify command or a double reset. So a pulse length is only a minimum from the host's side.

The command codes, the identifier codes, the pulse lengths in clock cycles, the address width and the strobe edge that latches a write are all parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read-array mode. Both pulses and both margin flags are low. A read returns `arr_rdata` with `arr_addr` equal to the bus address.
- R2: `dq_drive` is high only while `cs_n`=0, `oe_n`=0 and `we_n`=1. While `dq_drive` is low, `dq_out` is 0.
- R3: After the identify code (0x90), a read with address bit 0 = 0 returns MFR_CODE and a read with address bit 0 = 1 returns DEV_CODE. The read code (0x00) returns the controller to array data.
- R4: After the program-setup code (0x40), the next write latches its address onto `pgm_addr` and its data onto `pgm_data`. `prog_pulse` then stays high for exactly PROG_CYCLES clock cycles, starting in the cycle after that write is taken.
- R5: When the stop timer ends a pulse, the pulse drops and the controller stays inactive. Every command except the matching verify and a double reset is ignored. While inactive after a program, reads return array data at the latched program address.
- R6: The program-verify code (0xC0) ends a running program pulse in the cycle after the write. It raises `margin_hi`, and reads then return array data at the latched address whatever the bus address is.
- R7: The erase-setup code (0x20) followed by the same code as confirmation raises `erase_pulse` for exactly ERASE_CYCLES cycles. Any other second write cancels the erase and returns to read-array mode with no pulse.
- R8: The erase-verify code (0xA0), written during or after an erase pulse, ends the pulse and latches the write's address. It raises `margin_lo`, and reads return array data at that address.
- R9: Two consecutive writes of the reset code (0xFF) return the controller to read-array mode from any state after setup, and end any running pulse. A single 0xFF does not.
- R10: While `hv_ok` is low, the program-setup, erase-setup and both verify codes are ignored: no pulse, no latch, no margin flag. Identify and read still work.
- R11: When `hv_ok` is low in a cycle, any pulse, verify or inactive state ends, and read-array mode holds from the next cycle on.
- R12: `prog_pulse`, `erase_pulse`, `margin_hi` and `margin_lo` are never high at the same time. `pulse_busy` is the OR of the two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| hv_ok | input | 1 | High programming voltage present |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Bus address |
| dq_in | input | DW | Data written by the host |
| dq_out | output | DW | Data returned to the host |
| dq_drive | output | 1 | Data pins driven (else high impedance) |
| arr_addr | output | AW | Address presented to the array |
| arr_rdata | input | DW | Word read from the array |
| pgm_addr | output | AW | Latched program or verify address |
| pgm_data | output | DW | Latched program data |
| prog_pulse | output | 1 | Program pulse toward the array |
| erase_pulse | output | 1 | Erase pulse toward the array |
| pulse_busy | output | 1 | A stop-timed pulse is running |
| margin_hi | output | 1 | Array sense at program-verify margin |
| margin_lo | output | 1 | Array sense at erase-verify margin |

## Verification
A write is taken on the clock edge that sees the end of the strobe. The new state and every output derived from it are due one edge later. The bench drives inputs on falling edges and reads results on the falling edge after the write task returns. Read data and `dq_drive` are combinational from the bus pins and the state, so the bench samples them a few nanoseconds after it changes the pins, in the same low clock phase. Pulse lengths are counted in falling edges from the first one after the write, so a pulse off by one cycle shows up as a count mismatch. An `hv_ok` drop is checked at the next falling edge.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
   typedef enum logic [3:0] {
      ST_ARRAY,
      ST_IDENT,
      ST_ESETUP,
      ST_ERASING,
      ST_EDONE,
      ST_EVERIFY,
      ST_PSETUP,
      ST_PROGRAMMING,
      ST_PDONE,
      ST_PVERIFY
   } fcr_state_e;
endpackage

// File: rtl/fcr_bus_sense.sv
module fcr_bus_sense #(
   parameter bit LATCH_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic we_n,
   output logic wr_evt
);
   logic we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   generate
      if (LATCH_ON_RISE) begin : g_rise
         assign wr_evt = !we_q && we_n && !cs_n;
      end else begin : g_fall
         assign wr_evt = we_q && !we_n && !cs_n;
      end
   endgenerate

   // R4: one strobe yields exactly one write event
   p_single_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !wr_evt);
endmodule

// File: rtl/fcr_stop_timer.sv
module fcr_stop_timer #(
   parameter int PROG_CYCLES  = 25,
   parameter int ERASE_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_prog,
   input  logic load_erase,
   input  logic halt,
   output logic running,
   output logic expire
);
   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int TW   = $clog2(MAXC + 1);

   generate
      if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_len
         $error("pulse lengths must be at least one cycle");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (halt)       cnt <= '0;
      else if (load_prog)  cnt <= TW'(PROG_CYCLES);
      else if (load_erase) cnt <= TW'(ERASE_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign running = (cnt != '0);
   assign expire  = (cnt == TW'(1));

   // R4: an undisturbed pulse counts down by one per cycle
   p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !expire && !halt && !load_prog && !load_erase)
      |=> (running && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fcr_sequencer.sv
module fcr_sequencer
   import fcr_pkg::*;
#(
   parameter int          AW              = 18,
   parameter int          DW              = 8,
   parameter logic [DW-1:0] CMD_READ        = 8'h00,
   parameter logic [DW-1:0] CMD_IDENT       = 8'h90,
   parameter logic [DW-1:0] CMD_ERASE_SETUP = 8'h20,
   parameter logic [DW-1:0] CMD_ERASE_VER   = 8'hA0,
   parameter logic [DW-1:0] CMD_PROG_SETUP  = 8'h40,
   parameter logic [DW-1:0] CMD_PROG_VER    = 8'hC0,
   parameter logic [DW-1:0] CMD_RESET       = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          wr_evt,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic          tmr_expire,
   output fcr_state_e    state,
   output logic          load_prog,
   output logic          load_erase,
   output logic          tmr_halt,
   output logic [AW-1:0] lat_addr,
   output logic [DW-1:0] lat_data
);
   generate
      if (CMD_ERASE_SETUP == CMD_PROG_SETUP || CMD_ERASE_VER == CMD_PROG_VER ||
          CMD_RESET == CMD_READ || CMD_IDENT == CMD_READ) begin : g_bad_codes
         $error("command codes must be distinct");
      end
   endgenerate

   fcr_state_e nxt;
   logic       rst_armed, arm_nxt, hv_q, lat_en;
   logic       is_rst, dbl_rst;

   assign is_rst  = wr_evt && (din == CMD_RESET);
   assign dbl_rst = is_rst && rst_armed;

   always_comb begin
      nxt        = state;
      load_prog  = 1'b0;
      load_erase = 1'b0;
      tmr_halt   = 1'b0;
      lat_en     = 1'b0;
      arm_nxt    = wr_evt ? (is_rst && !rst_armed) : rst_armed;
      if (!hv_ok || hv_q) begin
         if (!hv_ok) begin
            tmr_halt = 1'b1;
            if (hv_q || (state != ST_ARRAY && state != ST_IDENT)) nxt = ST_ARRAY;
            else if (wr_evt) begin
               if (din == CMD_READ)       nxt = ST_ARRAY;
               else if (din == CMD_IDENT) nxt = ST_IDENT;
               else if (dbl_rst)          nxt = ST_ARRAY;
            end
         end else begin
            unique case (state)
               ST_ARRAY, ST_IDENT, ST_EVERIFY, ST_PVERIFY: if (wr_evt) begin
                  if (din == CMD_READ)             nxt = ST_ARRAY;
                  else if (din == CMD_IDENT)       nxt = ST_IDENT;
                  else if (din == CMD_ERASE_SETUP) nxt = ST_ESETUP;
                  else if (din == CMD_PROG_SETUP)  nxt = ST_PSETUP;
                  else if (din == CMD_ERASE_VER) begin
                     nxt    = ST_EVERIFY;
                     lat_en = 1'b1;
                  end
                  else if (din == CMD_PROG_VER)    nxt = ST_PVERIFY;
                  else if (dbl_rst)                nxt = ST_ARRAY;
               end
               ST_PSETUP: if (wr_evt) begin
                  nxt       = ST_PROGRAMMING;
                  lat_en    = 1'b1;
                  load_prog = 1'b1;
                  arm_nxt   = 1'b0;
               end
               ST_ESETUP: if (wr_evt) begin
                  if (din == CMD_ERASE_SETUP) begin
                     nxt        = ST_ERASING;
                     load_erase = 1'b1;
                  end else nxt = ST_ARRAY;
               end
               ST_PROGRAMMING: begin
                  if (wr_evt && din == CMD_PROG_VER) begin
                     nxt      = ST_PVERIFY;
                     tmr_halt = 1'b1;
                  end else if (dbl_rst) begin
                     nxt      = ST_ARRAY;
                     tmr_halt = 1'b1;
                  end else if (tmr_expire) nxt = ST_PDONE;
               end
               ST_PDONE: begin
                  if (wr_evt && din == CMD_PROG_VER) nxt = ST_PVERIFY;
                  else if (dbl_rst)                  nxt = ST_ARRAY;
               end
               ST_ERASING: begin
                  if (wr_evt && din == CMD_ERASE_VER) begin
                     nxt      = ST_EVERIFY;
                     lat_en   = 1'b1;
                     tmr_halt = 1'b1;
                  end else if (dbl_rst) begin
                     nxt      = ST_ARRAY;
                     tmr_halt = 1'b1;
                  end else if (tmr_expire) nxt = ST_EDONE;
               end
               ST_EDONE: begin
                  if (wr_evt && din == CMD_ERASE_VER) begin
                     nxt    = ST_EVERIFY;
                     lat_en = 1'b1;
                  end else if (dbl_rst) nxt = ST_ARRAY;
               end
               default: nxt = ST_ARRAY;
            endcase
         end
      end else begin
         // high voltage just returned: stay in read-array for this cycle
         nxt      = ST_ARRAY;
         tmr_halt = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_ARRAY;
         rst_armed <= 1'b0;
         hv_q      <= 1'b0;
         lat_addr  <= '0;
         lat_data  <= '0;
      end else begin
         state     <= nxt;
         rst_armed <= arm_nxt;
         hv_q      <= hv_ok;
         if (lat_en) begin
            lat_addr <= addr;
            lat_data <= din;
         end
      end
   end

   // R5: timer expiry parks the controller in the inactive state
   p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROGRAMMING && tmr_expire && hv_ok && hv_q && !wr_evt)
      |=> (state == ST_PDONE));
   // R9: a second consecutive reset code returns to read-array mode
   p_dbl_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rst && rst_armed && state != ST_PSETUP) |=> (state == ST_ARRAY));
   // R11: no pulse, verify or inactive state survives a missing high voltage
   p_hv_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!hv_ok) |=> (state == ST_ARRAY || state == ST_IDENT));
   // R4: the write after program setup is latched
   p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PSETUP && wr_evt && hv_ok && hv_q)
      |=> (lat_addr == $past(addr) && lat_data == $past(din)));
endmodule

// File: rtl/fcr_read_path.sv
module fcr_read_path
   import fcr_pkg::*;
#(
   parameter int            AW       = 18,
   parameter int            DW       = 8,
   parameter logic [DW-1:0] MFR_CODE = 8'hA7,
   parameter logic [DW-1:0] DEV_CODE = 8'h3C
) (
   input  fcr_state_e    state,
   input  logic          cs_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lat_addr,
   input  logic [DW-1:0] arr_rdata,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] dq_out,
   output logic          dq_drive,
   output logic          margin_hi,
   output logic          margin_lo
);
   logic use_latched;
   logic [DW-1:0] rd_word;

   assign use_latched = (state == ST_PVERIFY) || (state == ST_EVERIFY) ||
                        (state == ST_PROGRAMMING) || (state == ST_PDONE);
   assign arr_addr  = use_latched ? lat_addr : addr;
   assign margin_hi = (state == ST_PVERIFY);
   assign margin_lo = (state == ST_EVERIFY);
   assign dq_drive  = !cs_n && !oe_n && we_n;

   always_comb begin
      if (state == ST_IDENT) rd_word = addr[0] ? DEV_CODE : MFR_CODE;
      else                   rd_word = arr_rdata;
   end

   assign dq_out = dq_drive ? rd_word : '0;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcr_pkg::*;
#(
   parameter int            AW              = 18,
   parameter int            DW              = 8,
   parameter int            PROG_CYCLES     = 25,
   parameter int            ERASE_CYCLES    = 200,
   parameter bit            LATCH_ON_RISE   = 1'b1,
   parameter logic [DW-1:0] MFR_CODE        = 8'hA7,
   parameter logic [DW-1:0] DEV_CODE        = 8'h3C,
   parameter logic [DW-1:0] CMD_READ        = 8'h00,
   parameter logic [DW-1:0] CMD_IDENT       = 8'h90,
   parameter logic [DW-1:0] CMD_ERASE_SETUP = 8'h20,
   parameter logic [DW-1:0] CMD_ERASE_VER   = 8'hA0,
   parameter logic [DW-1:0] CMD_PROG_SETUP  = 8'h40,
   parameter logic [DW-1:0] CMD_PROG_VER    = 8'hC0,
   parameter logic [DW-1:0] CMD_RESET       = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          cs_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] dq_out,
   output logic          dq_drive,
   output logic [AW-1:0] arr_addr,
   input  logic [DW-1:0] arr_rdata,
   output logic [AW-1:0] pgm_addr,
   output logic [DW-1:0] pgm_data,
   output logic          prog_pulse,
   output logic          erase_pulse,
   output logic          pulse_busy,
   output logic          margin_hi,
   output logic          margin_lo
);
   generate
      if (AW < 1 || DW < 8) begin : g_bad_width
         $error("address must be at least 1 bit and data at least 8 bits");
      end
   endgenerate

   fcr_state_e state;
   logic wr_evt, load_prog, load_erase, tmr_halt, tmr_running, tmr_expire;

   fcr_bus_sense #(.LATCH_ON_RISE(LATCH_ON_RISE)) u_sense (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .wr_evt(wr_evt));

   fcr_stop_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_prog(load_prog), .load_erase(load_erase),
      .halt(tmr_halt), .running(tmr_running), .expire(tmr_expire));

   fcr_sequencer #(
      .AW(AW), .DW(DW), .CMD_READ(CMD_READ), .CMD_IDENT(CMD_IDENT),
      .CMD_ERASE_SETUP(CMD_ERASE_SETUP), .CMD_ERASE_VER(CMD_ERASE_VER),
      .CMD_PROG_SETUP(CMD_PROG_SETUP), .CMD_PROG_VER(CMD_PROG_VER),
      .CMD_RESET(CMD_RESET)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_evt(wr_evt), .addr(addr),
      .din(dq_in), .tmr_expire(tmr_expire), .state(state),
      .load_prog(load_prog), .load_erase(load_erase), .tmr_halt(tmr_halt),
      .lat_addr(pgm_addr), .lat_data(pgm_data));

   fcr_read_path #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
      .state(state), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .lat_addr(pgm_addr), .arr_rdata(arr_rdata), .arr_addr(arr_addr),
      .dq_out(dq_out), .dq_drive(dq_drive), .margin_hi(margin_hi),
      .margin_lo(margin_lo));

   assign prog_pulse  = (state == ST_PROGRAMMING);
   assign erase_pulse = (state == ST_ERASING);
   assign pulse_busy  = prog_pulse || erase_pulse;

   // R12: array-side controls are mutually exclusive
   p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_pulse, erase_pulse, margin_hi, margin_lo}));
   // R5: a pulse state never outlives its stop timer
   p_pulse_timed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_busy |-> tmr_running);
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
   localparam int AW = 18;
   localparam int PC = 25;
   localparam int EC = 200;
   localparam logic [7:0] MFR = 8'hA7;
   localparam logic [7:0] DEV = 8'h3C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hv_ok = 1'b0;
   logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0] dq_in = '0;
   logic [7:0] dq_out, arr_rdata, pgm_data;
   logic [AW-1:0] arr_addr, pgm_addr;
   logic dq_drive, prog_pulse, erase_pulse, pulse_busy, margin_hi, margin_lo;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   // array model: word = low address byte XOR 0x5A
   assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

   flash_cmd_ctrl #(.AW(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
                    .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .cs_n(cs_n), .oe_n(oe_n),
      .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_drive(dq_drive), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
      .pgm_addr(pgm_addr), .pgm_data(pgm_data), .prog_pulse(prog_pulse),
      .erase_pulse(erase_pulse), .pulse_busy(pulse_busy),
      .margin_hi(margin_hi), .margin_lo(margin_lo));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic drv);
      @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      #1; d = dq_out; drv = dq_drive;
      oe_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic count_pulse(input bit erase, output int n);
      n = 0;
      while ((erase ? erase_pulse : prog_pulse) && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state;
      logic [7:0] d; logic v;
      chk("R1 busy", pulse_busy, 0);
      chk("R1 margins", {margin_hi, margin_lo}, 0);
      chk("R1 drive idle", dq_drive, 0);
      rd(18'h12, d, v);
      chk("R1 array read", d, 8'h12 ^ 8'h5A);
   endtask

   task automatic t_bus_drive;
      @(negedge clk); cs_n = 0; oe_n = 0; we_n = 0; #1;
      chk("R2 we low", {dq_drive, dq_out}, 0);
      cs_n = 1; we_n = 1; #1;
      chk("R2 cs high", {dq_drive, dq_out}, 0);
      cs_n = 0; oe_n = 1; #1;
      chk("R2 oe high", {dq_drive, dq_out}, 0);
      oe_n = 0; #1;
      chk("R2 all active", dq_drive, 1);
      oe_n = 1; cs_n = 1;
   endtask

   task automatic t_ident;
      logic [7:0] d; logic v;
      wr(0, 8'h90);
      rd(18'h100, d, v); chk("R3 manufacturer", d, MFR);
      rd(18'h001, d, v); chk("R3 device", d, DEV);
      wr(0, 8'h00);
      rd(18'h001, d, v); chk("R3 back to array", d, 8'h01 ^ 8'h5A);
   endtask

   task automatic t_program;
      logic [7:0] d; logic v; int n;
      wr(0, 8'h40);
      wr(18'h033, 8'h77);
      chk("R4 pgm_addr", pgm_addr, 18'h033);
      chk("R4 pgm_data", pgm_data, 8'h77);
      count_pulse(1'b0, n);
      chk("R4 program pulse length", n, PC);
      chk("R5 inactive no pulse", pulse_busy, 0);
      wr(0, 8'h90);
      rd(0, d, v);
      chk("R5 identify ignored while inactive", d, 8'h33 ^ 8'h5A);
      wr(0, 8'hC0);
      chk("R6 margin_hi", margin_hi, 1);
      rd(18'h010, d, v);
      chk("R6 verify at latched address", d, 8'h33 ^ 8'h5A);
   endtask

   task automatic t_early_verify;
      logic [7:0] d; logic v;
      wr(0, 8'h40);
      wr(18'h044, 8'h11);
      repeat (3) @(negedge clk);
      chk("R6 pulse running", prog_pulse, 1);
      wr(0, 8'hC0);
      chk("R6 pulse ended by verify", prog_pulse, 0);
      chk("R6 margin_hi early", margin_hi, 1);
      rd(18'h001, d, v);
      chk("R6 early verify data", d, 8'h44 ^ 8'h5A);
   endtask

   task automatic t_erase;
      logic [7:0] d; logic v; int n;
      wr(0, 8'h20);
      wr(0, 8'h20);
      count_pulse(1'b1, n);
      chk("R7 erase pulse length", n, EC);
      wr(18'h021, 8'hA0);
      chk("R8 margin_lo", margin_lo, 1);
      rd(0, d, v);
      chk("R8 erase verify data", d, 8'h21 ^ 8'h5A);
      wr(0, 8'h20);
      wr(0, 8'h20);
      repeat (4) @(negedge clk);
      wr(18'h02B, 8'hA0);
      chk("R8 verify ends erase pulse", erase_pulse, 0);
      rd(0, d, v);
      chk("R8 early erase verify data", d, 8'h2B ^ 8'h5A);
      wr(0, 8'h20);
      wr(0, 8'h00);
      chk("R7 cancelled erase", {erase_pulse, margin_lo}, 0);
      rd(18'h005, d, v);
      chk("R7 cancel returns to array", d, 8'h05 ^ 8'h5A);
   endtask

   task automatic t_reset_cmd;
      logic [7:0] d; logic v;
      wr(0, 8'h40);
      wr(18'h050, 8'h01);
      wr(0, 8'hFF);
      chk("R9 single reset ignored", prog_pulse, 1);
      wr(0, 8'hFF);
      chk("R9 double reset stops pulse", pulse_busy, 0);
      rd(18'h002, d, v);
      chk("R9 array after reset", d, 8'h02 ^ 8'h5A);
   endtask

   task automatic t_hv_low;
      logic [7:0] d; logic v;
      hv_ok = 1'b0;
      @(negedge clk);
      wr(0, 8'h40);
      wr(18'h060, 8'h22);
      chk("R10 no program pulse", pulse_busy, 0);
      chk("R10 no latch", pgm_addr, 18'h050);
      wr(18'h061, 8'hA0);
      chk("R10 erase verify ignored", margin_lo, 0);
      wr(0, 8'h90);
      rd(0, d, v);
      chk("R10 identify works", d, MFR);
      wr(0, 8'h00);
   endtask

   task automatic t_hv_drop;
      logic [7:0] d; logic v;
      hv_ok = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(0, 8'h40);
      wr(18'h070, 8'h01);
      chk("R11 pulse before drop", prog_pulse, 1);
      hv_ok = 1'b0;
      @(negedge clk);
      chk("R11 pulse gone", pulse_busy, 0);
      hv_ok = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11 stays read-array", pulse_busy, 0);
      rd(18'h003, d, v);
      chk("R11 array data", d, 8'h03 ^ 8'h5A);
   endtask

   initial begin
      #1_200_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_bus_drive();
      hv_ok = 1'b1;
      repeat (2) @(negedge clk);
      t_ident();
      t_program();
      t_early_verify();
      t_erase();
      t_reset_cmd();
      t_hv_low();
      t_hv_drop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule